// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides which local interrupt a hart should take next. Each cycle it looks at the pending and enable vectors, the delegation mask, the current privilege level and the two global interrupt-enable bits. From these it forms the set of interrupts that may actually be taken. Interrupts handled at machine level are gated by the machine global enable. Interrupts delegated to supervisor level are gated by the supervisor global enable. From the merged set it picks the lowest-numbered interrupt.

The result is registered once per clock. It appears as a valid flag and an interrupt index. The block also produces a side vector for a virtualized supervisor. The virtual-supervisor software, timer and external lines are removed from the normal set. Their pending-and-enabled values are shifted down by one position so that they line up with the ordinary supervisor lines. The trap entry logic of the core reads these outputs. The block itself writes no state beyond its output registers.

Top module: `irq_sel`

## Requirements
- R1: An interrupt is a candidate only when its pending bit and its enable bit are both 1. A pending but disabled line is never selected.
- R2: The machine-level gate is open when the privilege is user (0) or supervisor (1). It is also open when the privilege is machine (3) and the machine enable input is 1.
- R3: The supervisor-level gate is open when the privilege is user (0). It is also open when the privilege is supervisor (1) and the supervisor enable input is 1. At machine privilege it is always closed.
- R4: A candidate whose delegation bit is 0 passes through the machine-level gate. A candidate whose delegation bit is 1 passes through the supervisor-level gate. The two results are merged by OR.
- R5: When the merged set is non-zero, the index reported is that of its lowest set bit, and valid is 1.
- R6: When the merged set is zero, valid is 0 and the index is 0.
- R7: Bit positions set in the virtual-supervisor mask (by default bits 2, 6 and 10) never enter the merged set. This holds whatever their pending, enable and delegation bits are.
- R8: The virtual-supervisor output bit i equals pending AND enable of bit i+1, restricted to the virtual-supervisor mask. Its top bit is 0.
- R9: All outputs reflect the inputs sampled at the previous rising clock edge, with exactly one register stage.
- R10: A synchronous active-high reset clears valid, the index and the virtual-supervisor output on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pend_i | input | W | Pending interrupt lines |
| en_i | input | W | Per-line interrupt enables |
| deleg_i | input | W | Per-line delegation to supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| valid_o | output | 1 | An interrupt is selected |
| idx_o | output | IW | Index of the selected interrupt |
| vs_align_o | output | W | Virtual-supervisor lines shifted down by one |

## Verification
The bench builds the block with its defaults: W = 16 lines, virtual-supervisor exclusion on, and the mask at bits 2, 6 and 10. With W = 16, both the lowest line and the highest line (15) can be reached as the selected index. With the exclusion on, a vector can be pending and enabled at the excluded positions alone, so the bench can show that it produces no selection while still appearing on the shifted side output. Every privilege level is crossed with both global enables and with mixed delegation masks. This shows each gate opening and closing on its own.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_MACH  = 2'd3
  } lvl_e;

  // Machine-level gate: open below machine, or at machine with its enable set.
  function automatic logic mach_gate(input logic [1:0] lvl, input logic m_ie);
    return (lvl != LVL_MACH) || m_ie;
  endfunction

  // Supervisor-level gate: open at user, or at supervisor with its enable set.
  function automatic logic super_gate(input logic [1:0] lvl, input logic s_ie);
    return (lvl == LVL_USER) || ((lvl == LVL_SUPER) && s_ie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       mie_i,
  input  logic       sie_i,
  output logic       m_open_o,
  output logic       s_open_o
);
  always_comb begin
    m_open_o = mach_gate(priv_i, mie_i);
    s_open_o = super_gate(priv_i, sie_i);
  end
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int          W       = 16,
  parameter bit          VS_EXCL = 1'b1,
  parameter logic [W-1:0] VS_MASK = W'(16'h0444)
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] deleg_i,
  input  logic         m_open_i,
  input  logic         s_open_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] vs_align_o
);
  logic [W-1:0] cand;
  logic [W-1:0] normal;
  logic [W-1:0] vs_raw;

  assign cand   = pend_i & en_i;
  assign vs_raw = cand & VS_MASK;

  generate
    if (VS_EXCL) begin : g_excl
      assign normal = cand & ~VS_MASK;
    end else begin : g_keep
      assign normal = cand;
    end
  endgenerate

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit_o[i] = normal[i] & (deleg_i[i] ? s_open_i : m_open_i);
  end

  assign vs_align_o = vs_raw >> 1;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_sel.sv
module irq_sel #(
  parameter int           W       = 16,
  parameter bit           VS_EXCL = 1'b1,
  parameter logic [W-1:0] VS_MASK = W'(16'h0444),
  localparam int          IW      = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  en_i,
  input  logic [W-1:0]  deleg_i,
  input  logic [1:0]    priv_i,
  input  logic          mie_i,
  input  logic          sie_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  vs_align_o
);
  logic          m_open;
  logic          s_open;
  logic [W-1:0]  hit_vec;
  logic [W-1:0]  vs_next;
  logic          any_hit;
  logic [IW-1:0] pick_idx;

  irq_gate u_gate (
    .priv_i   (priv_i),
    .mie_i    (mie_i),
    .sie_i    (sie_i),
    .m_open_o (m_open),
    .s_open_o (s_open)
  );

  irq_mask #(.W(W), .VS_EXCL(VS_EXCL), .VS_MASK(VS_MASK)) u_mask (
    .pend_i     (pend_i),
    .en_i       (en_i),
    .deleg_i    (deleg_i),
    .m_open_i   (m_open),
    .s_open_i   (s_open),
    .hit_o      (hit_vec),
    .vs_align_o (vs_next)
  );

  irq_pick #(.W(W), .IW(IW)) u_pick (
    .vec_i (hit_vec),
    .any_o (any_hit),
    .idx_o (pick_idx)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o    <= 1'b0;
      idx_o      <= '0;
      vs_align_o <= '0;
    end else begin
      valid_o    <= any_hit;
      idx_o      <= pick_idx;
      vs_align_o <= vs_next;
    end
  end
endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk #(
  parameter int           W       = 16,
  parameter bit           VS_EXCL = 1'b1,
  parameter logic [W-1:0] VS_MASK = W'(16'h0444),
  localparam int          IW      = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic [W-1:0]  pend_i,
  input logic [W-1:0]  en_i,
  input logic [W-1:0]  deleg_i,
  input logic [1:0]    priv_i,
  input logic          mie_i,
  input logic          sie_i,
  input logic [W-1:0]  hit_vec,
  input logic          valid_o,
  input logic [IW-1:0] idx_o,
  input logic [W-1:0]  vs_align_o
);
  logic [W-1:0] pe_q, deleg_q, hit_q;
  logic [1:0]   priv_q;
  logic         mie_q, sie_q, rst_q;
  logic [W-1:0] below_idx;

  always_ff @(posedge clk_i) begin
    pe_q    <= pend_i & en_i;
    deleg_q <= deleg_i;
    hit_q   <= hit_vec;
    priv_q  <= priv_i;
    mie_q   <= mie_i;
    sie_q   <= sie_i;
    rst_q   <= rst_i;
  end

  assign below_idx = (W'(1) << idx_o) - W'(1);

  a_r1_cand_only: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> pe_q[idx_o]);

  a_r2_mach_closed: assert property (@(posedge clk_i) disable iff (rst_i)
    (priv_q == 2'd3 && !mie_q) |-> !valid_o);

  a_r3_no_deleg_in_mach: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && priv_q == 2'd3) |-> !deleg_q[idx_o]);

  a_r4_super_closed: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && priv_q == 2'd1 && !sie_q) |-> !deleg_q[idx_o]);

  a_r5_lowest: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> ((hit_q & below_idx) == '0));

  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> (idx_o == '0));

  generate
    if (VS_EXCL) begin : g_vs_chk
      a_r7_vs_excluded: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> !VS_MASK[idx_o]);
    end
  endgenerate

  a_r8_vs_top_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    !vs_align_o[W-1]);

  a_r10_reset_clear: assert property (@(posedge clk_i)
    rst_q |-> (!valid_o && idx_o == '0 && vs_align_o == '0));
endmodule

bind irq_sel irq_sel_chk #(.W(W), .VS_EXCL(VS_EXCL), .VS_MASK(VS_MASK)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .pend_i     (pend_i),
  .en_i       (en_i),
  .deleg_i    (deleg_i),
  .priv_i     (priv_i),
  .mie_i      (mie_i),
  .sie_i      (sie_i),
  .hit_vec    (hit_vec),
  .valid_o    (valid_o),
  .idx_o      (idx_o),
  .vs_align_o (vs_align_o)
);

// File: tb/irq_sel_bench.sv
`timescale 1ns/1ps
module irq_sel_bench;
  localparam int           W   = 16;
  localparam int           IW  = 4;
  localparam logic [W-1:0] VSM = 16'h0444;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  pend, en, deleg;
  logic [1:0]    priv;
  logic          mie, sie;
  logic          valid;
  logic [IW-1:0] idx;
  logic [W-1:0]  vs;

  always #2 clk = ~clk;

  irq_sel u_irq_sel (
    .clk_i (clk), .rst_i (rst), .pend_i (pend), .en_i (en), .deleg_i (deleg),
    .priv_i (priv), .mie_i (mie), .sie_i (sie),
    .valid_o (valid), .idx_o (idx), .vs_align_o (vs)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic          ev_q[$];
  logic [IW-1:0] ei_q[$];
  logic [W-1:0]  es_q[$];
  string         tag_q[$];

  // Independent model: walk upward, accept the first line whose gate is open.
  task automatic model(input logic [W-1:0] p, e, d, input logic [1:0] pr,
                       input logic mi, si, output logic v,
                       output logic [IW-1:0] ix, output logic [W-1:0] sv);
    v = 1'b0; ix = '0; sv = '0;
    for (int i = 0; i < W; i++) begin
      logic ok;
      if (d[i]) ok = (pr == 2'd0) || (pr == 2'd1 && si);
      else      ok = (pr != 2'd3) || mi;
      if (!v && p[i] && e[i] && !VSM[i] && ok) begin
        v = 1'b1; ix = IW'(i);
      end
    end
    for (int i = 0; i < W - 1; i++) sv[i] = p[i+1] & e[i+1] & VSM[i+1];
  endtask

  task automatic drive(input logic [W-1:0] p, e, d, input logic [1:0] pr,
                       input logic mi, si, input string tag);
    logic v; logic [IW-1:0] ix; logic [W-1:0] sv;
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pr; mie = mi; sie = si;
    model(p, e, d, pr, mi, si, v, ix, sv);
    ev_q.push_back(v); ei_q.push_back(ix); es_q.push_back(sv); tag_q.push_back(tag);
  endtask

  // Monitor: one register stage (R9), so compare just after the next edge.
  always @(posedge clk) begin
    #1;
    if (ev_q.size() > 0) begin
      logic v; logic [IW-1:0] ix; logic [W-1:0] sv; string t;
      v = ev_q.pop_front(); ix = ei_q.pop_front(); sv = es_q.pop_front(); t = tag_q.pop_front();
      n_chk++;
      if (valid !== v || idx !== ix || vs !== sv) begin
        n_fail++;
        $display("FAIL %s R9: got v=%0b idx=%0d vs=%h, exp v=%0b idx=%0d vs=%h",
                 t, valid, idx, vs, v, ix, sv);
      end
    end
  end

  task automatic check_reset(input string tag);
    n_chk++;
    if (valid !== 1'b0 || idx !== '0 || vs !== '0) begin
      n_fail++;
      $display("FAIL %s R10: got v=%0b idx=%0d vs=%h, exp v=0 idx=0 vs=0",
               tag, valid, idx, vs);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog R9: got hung run, exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; pend = 16'hffff; en = 16'hffff; deleg = '0; priv = 2'd0; mie = 1'b1; sie = 1'b1;
    repeat (3) @(posedge clk);
    #1 check_reset("R10 power-on");
    @(negedge clk) rst = 1'b0;

    drive(16'h00a0, 16'h00ff, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 user lowest");
    drive(16'h0880, 16'h0080, 16'h0000, 2'd0, 1'b0, 1'b0, "R1 disabled bit skipped");
    drive(16'h0808, 16'h0800, 16'h0000, 2'd0, 1'b0, 1'b0, "R1 only enabled bit");
    drive(16'h0880, 16'h0880, 16'h0000, 2'd3, 1'b0, 1'b1, "R2 mach closed");
    drive(16'h0880, 16'h0880, 16'h0000, 2'd3, 1'b1, 1'b0, "R2 mach open");
    drive(16'h0880, 16'h0880, 16'h0000, 2'd1, 1'b0, 1'b0, "R2 below mach open");
    drive(16'h0022, 16'h0022, 16'h0022, 2'd3, 1'b1, 1'b1, "R3 deleg closed at mach");
    drive(16'h0022, 16'h0022, 16'h0002, 2'd1, 1'b1, 1'b0, "R4 sie off, nondeleg wins");
    drive(16'h0022, 16'h0022, 16'h0002, 2'd1, 1'b0, 1'b1, "R4 sie on, deleg wins");
    drive(16'h0022, 16'h0022, 16'h0022, 2'd0, 1'b0, 1'b0, "R3 user super open");
    drive(16'h0444, 16'hffff, 16'h0000, 2'd0, 1'b1, 1'b1, "R7 R8 vs only");
    drive(16'h0644, 16'hffff, 16'h0000, 2'd0, 1'b1, 1'b1, "R7 skip vs to bit 9");
    drive(16'h8000, 16'h8000, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 top bit 15");
    drive(16'h0000, 16'hffff, 16'hffff, 2'd0, 1'b1, 1'b1, "R6 none pending");
    drive(16'h0001, 16'h0001, 16'h0001, 2'd1, 1'b1, 1'b0, "R6 all blocked");
    drive(16'h0001, 16'h0001, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 bit 0");

    for (int k = 0; k < 300; k++) begin
      logic [1:0] pr;
      case ($urandom_range(0, 2))
        0:       pr = 2'd0;
        1:       pr = 2'd1;
        default: pr = 2'd3;
      endcase
      drive(W'($urandom), W'($urandom), W'($urandom), pr, 1'($urandom), 1'($urandom),
            "R4 R5 random");
    end

    drive(16'h0010, 16'h0010, 16'h0000, 2'd0, 1'b0, 1'b0, "R9 before reset");
    @(posedge clk);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 check_reset("R10 mid-run");
    @(negedge clk) rst = 1'b0;
    drive(16'h0100, 16'h0100, 16'h0000, 2'd0, 1'b0, 1'b0, "R9 after reset");
    repeat (3) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule